// File: doc/BRIEF.md
# Serial Link PHY Power-State Controller

This block tracks the interface power state on one side of a serial storage link. After the first full power-on sequence has brought the link up and settled on a line rate, the controller keeps that rate in a register. It then moves the PHY between an active state and two reduced-power states. In the active state the PHY logic and PLL run and the link can carry data. The lighter reduced-power state, Partial, idles both lines at common mode. The deeper one, Slumber, saves more power and needs a longer wake time.

Either end of the link can start a wake. The controller does not repeat calibration or speed negotiation. It re-enters the out-of-band sequence at the COMWAKE step. When this side starts the wake, it drives COMWAKE itself. When the far end starts it, this side only answers. In both cases ALIGN is sent at the saved rate. A cycle counter limits how long the wake may take. The limit depends on which reduced-power state is being left. If the link is not back within that limit, the controller flags a fault and falls back to the full-reset state, which clears the saved rate.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, and until the first accepted `init_done`, the block is in its off state. In that state `phy_ready`=0, `pwr_state`=3, `comwake_tx`=0, `align_tx`=0, `exit_fault`=0 and `link_speed`=0.
- R2: In the off state, `init_done`=1 at a clock edge moves the block to the active state. After that edge `phy_ready`=1, `pwr_state`=0, and `link_speed` equals the `init_speed` value sampled at that edge.
- R3: In the active state, `pd_slumber_req` moves the block to Slumber (`pwr_state`=2). Otherwise `pd_partial_req` moves it to Partial (`pwr_state`=1). When both are high, Slumber wins.
- R4: Power-down requests have no effect in any state other than the active state.
- R5: In Partial or Slumber, `wake_remote` moves the block to the responder wake state: `pwr_state`=3, `align_tx`=1, `comwake_tx`=0, `phy_ready`=0.
- R6: In Partial or Slumber, `wake_local` alone moves the block to the initiator wake state: `pwr_state`=3, `comwake_tx`=1, `align_tx`=1.
- R7: When `wake_local` and `wake_remote` are both high in the same cycle in Partial or Slumber, the responder wake state is taken, so `comwake_tx` stays 0.
- R8: In either wake state, `link_up`=1 returns the block to the active state at the next edge without `init_done`. This still works on the last cycle of the limit.
- R9: `link_speed` is changed by no power-state transition. `init_done` and `init_speed` are ignored outside the off state.
- R10: A wake from Partial that sees no `link_up` on any of its first `PARTIAL_EXIT_CYC` edges raises `exit_fault` for exactly one cycle. The block then returns to the off state with `link_speed`=0.
- R11: A wake from Slumber uses `SLUMBER_EXIT_CYC` as its limit in the same way.
- R12: `wake_local` and `wake_remote` have no effect in the off state and in the active state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Full power-on and speed negotiation completed |
| init_speed | input | SPD_W | Line rate chosen by negotiation |
| pd_partial_req | input | 1 | Request to enter Partial |
| pd_slumber_req | input | 1 | Request to enter Slumber |
| wake_local | input | 1 | This side wants to leave low power |
| wake_remote | input | 1 | COMWAKE detected from far end |
| link_up | input | 1 | ALIGN lock regained after wake |
| phy_ready | output | 1 | Link active and able to carry data |
| pwr_state | output | 2 | 0 active, 1 Partial, 2 Slumber, 3 off/wake/fault |
| comwake_tx | output | 1 | Drive COMWAKE toward the far end |
| align_tx | output | 1 | Send ALIGN primitives at `link_speed` |
| link_speed | output | SPD_W | Saved line rate |
| exit_fault | output | 1 | One-cycle pulse on wake timeout |

## Verification
The assertions check these rules on every cycle:
- how the rate is captured, and that it holds steady while the link is active;
- that power-down requests reach only the active state;
- that a far-end wake wins over a local one;
- the one-cycle fault pulse and the reset that follows it.

Only the bench scenarios show the exact cycle at which each wake limit expires. They also show that `link_up` on the last allowed edge still succeeds. Finally, they show that the limit is chosen by whether the wake started from Partial or from Slumber.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_READY    = 3'd1,
    ST_PARTIAL  = 3'd2,
    ST_SLUMBER  = 3'd3,
    ST_WAKE_LCL = 3'd4,
    ST_WAKE_RMT = 3'd5,
    ST_FAULT    = 3'd6
  } lpc_state_e;

  localparam logic [1:0] PS_ACTIVE  = 2'd0;
  localparam logic [1:0] PS_PARTIAL = 2'd1;
  localparam logic [1:0] PS_SLUMBER = 2'd2;
  localparam logic [1:0] PS_TRANSIT = 2'd3;

endpackage

// File: rtl/lpc_wake_arb.sv
module lpc_wake_arb (
  input  logic en,
  input  logic wake_local,
  input  logic wake_remote,
  output logic take_local,
  output logic take_remote
);

  // far-end COMWAKE has priority so only one side drives the wake burst
  always_comb begin
    take_remote = en & wake_remote;
    take_local  = en & wake_local & ~wake_remote;
  end

endmodule

// File: rtl/lpc_speed_hold.sv
module lpc_speed_hold #(
  parameter int SPD_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [SPD_W-1:0] speed_in,
  output logic [SPD_W-1:0] speed_q
);

  logic             en;
  logic [SPD_W-1:0] speed_d;

  always_comb begin
    en      = load | clear;
    speed_d = clear ? '0 : speed_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= '0;
    end else if (en) begin
      speed_q <= speed_d;
    end
  end

endmodule

// File: rtl/lpc_exit_timer.sv
module lpc_exit_timer #(
  parameter int PARTIAL_EXIT_CYC = 1000,
  parameter int SLUMBER_EXIT_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic arm_slumber,
  input  logic run,
  output logic expired
);

  localparam int MAX_CYC = (SLUMBER_EXIT_CYC > PARTIAL_EXIT_CYC) ?
                           SLUMBER_EXIT_CYC : PARTIAL_EXIT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PAR_LAST = CNT_W'(PARTIAL_EXIT_CYC - 1);
  localparam logic [CNT_W-1:0] SLU_LAST = CNT_W'(SLUMBER_EXIT_CYC - 1);

  logic             lim_slumber_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] last;

  always_comb begin
    last    = lim_slumber_q ? SLU_LAST : PAR_LAST;
    expired = run & (cnt_q == last);
    cnt_en  = run | (cnt_q != '0);
    cnt_d   = run ? (cnt_q + CNT_W'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_slumber_q <= 1'b0;
    end else if (arm) begin
      lim_slumber_q <= arm_slumber;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lpc_fsm.sv
module lpc_fsm
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_done,
  input  logic       pd_partial_req,
  input  logic       pd_slumber_req,
  input  logic       take_local,
  input  logic       take_remote,
  input  logic       link_up,
  input  logic       expired,
  output lpc_state_e state_q,
  output logic       low_pwr,
  output logic       arm,
  output logic       arm_slumber,
  output logic       wake_run,
  output logic       load_speed,
  output logic       clear_speed
);

  lpc_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF: begin
        if (init_done) state_d = ST_READY;
      end
      ST_READY: begin
        if (pd_slumber_req)      state_d = ST_SLUMBER;
        else if (pd_partial_req) state_d = ST_PARTIAL;
      end
      ST_PARTIAL, ST_SLUMBER: begin
        if (take_remote)     state_d = ST_WAKE_RMT;
        else if (take_local) state_d = ST_WAKE_LCL;
      end
      ST_WAKE_LCL, ST_WAKE_RMT: begin
        if (link_up)      state_d = ST_READY;
        else if (expired) state_d = ST_FAULT;
      end
      ST_FAULT: state_d = ST_OFF;
      default:  state_d = ST_OFF;
    endcase
  end

  always_comb begin
    low_pwr     = (state_q == ST_PARTIAL) | (state_q == ST_SLUMBER);
    arm         = low_pwr & (take_local | take_remote);
    arm_slumber = (state_q == ST_SLUMBER);
    wake_run    = (state_q == ST_WAKE_LCL) | (state_q == ST_WAKE_RMT);
    load_speed  = (state_q == ST_OFF) & init_done;
    clear_speed = (state_q == ST_FAULT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
  import lpc_pkg::*;
#(
  parameter int SPD_W            = 2,
  parameter int PARTIAL_EXIT_CYC = 1000,
  parameter int SLUMBER_EXIT_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done,
  input  logic [SPD_W-1:0] init_speed,
  input  logic             pd_partial_req,
  input  logic             pd_slumber_req,
  input  logic             wake_local,
  input  logic             wake_remote,
  input  logic             link_up,
  output logic             phy_ready,
  output logic [1:0]       pwr_state,
  output logic             comwake_tx,
  output logic             align_tx,
  output logic [SPD_W-1:0] link_speed,
  output logic             exit_fault
);

  lpc_state_e state_q;
  logic       low_pwr;
  logic       take_local;
  logic       take_remote;
  logic       arm;
  logic       arm_slumber;
  logic       wake_run;
  logic       expired;
  logic       load_speed;
  logic       clear_speed;

  lpc_wake_arb u_arb (
    .en          (low_pwr),
    .wake_local  (wake_local),
    .wake_remote (wake_remote),
    .take_local  (take_local),
    .take_remote (take_remote)
  );

  lpc_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .init_done      (init_done),
    .pd_partial_req (pd_partial_req),
    .pd_slumber_req (pd_slumber_req),
    .take_local     (take_local),
    .take_remote    (take_remote),
    .link_up        (link_up),
    .expired        (expired),
    .state_q        (state_q),
    .low_pwr        (low_pwr),
    .arm            (arm),
    .arm_slumber    (arm_slumber),
    .wake_run       (wake_run),
    .load_speed     (load_speed),
    .clear_speed    (clear_speed)
  );

  lpc_exit_timer #(
    .PARTIAL_EXIT_CYC (PARTIAL_EXIT_CYC),
    .SLUMBER_EXIT_CYC (SLUMBER_EXIT_CYC)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .arm_slumber (arm_slumber),
    .run         (wake_run),
    .expired     (expired)
  );

  lpc_speed_hold #(
    .SPD_W (SPD_W)
  ) u_speed (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_speed),
    .clear    (clear_speed),
    .speed_in (init_speed),
    .speed_q  (link_speed)
  );

  always_comb begin
    phy_ready  = (state_q == ST_READY);
    comwake_tx = (state_q == ST_WAKE_LCL);
    align_tx   = wake_run;
    exit_fault = (state_q == ST_FAULT);
    unique case (state_q)
      ST_READY:   pwr_state = PS_ACTIVE;
      ST_PARTIAL: pwr_state = PS_PARTIAL;
      ST_SLUMBER: pwr_state = PS_SLUMBER;
      default:    pwr_state = PS_TRANSIT;
    endcase
  end

endmodule

// File: rtl/lpc_checker.sv
module lpc_checker
  import lpc_pkg::*;
#(
  parameter int SPD_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_done,
  input logic [SPD_W-1:0] init_speed,
  input logic             pd_partial_req,
  input logic             pd_slumber_req,
  input logic             wake_local,
  input logic             wake_remote,
  input logic             link_up,
  input logic             phy_ready,
  input logic [1:0]       pwr_state,
  input logic             comwake_tx,
  input logic             align_tx,
  input logic [SPD_W-1:0] link_speed,
  input logic             exit_fault
);

  logic is_off;
  assign is_off = (pwr_state == PS_TRANSIT) & ~align_tx & ~exit_fault;

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_off |-> (!phy_ready && !comwake_tx));

  p_init_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_off && init_done) |=> (phy_ready && link_speed == $past(init_speed)));

  p_pd_slumber_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ready && pd_slumber_req) |=> (pwr_state == PS_SLUMBER));

  p_pd_partial_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ready && pd_partial_req && !pd_slumber_req) |=> (pwr_state == PS_PARTIAL));

  p_partial_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_PARTIAL && !wake_local && !wake_remote) |=> (pwr_state == PS_PARTIAL));

  p_slumber_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_SLUMBER && !wake_local && !wake_remote) |=> (pwr_state == PS_SLUMBER));

  p_remote_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == PS_PARTIAL || pwr_state == PS_SLUMBER) && wake_remote)
      |=> (align_tx && !comwake_tx));

  p_comwake_in_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    comwake_tx |-> (align_tx && !phy_ready));

  p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (align_tx && link_up) |=> (phy_ready && $stable(link_speed)));

  p_speed_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != PS_TRANSIT || align_tx) |=> $stable(link_speed));

  p_fault_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exit_fault |=> (!exit_fault && link_speed == '0 && pwr_state == PS_TRANSIT && !align_tx));

  p_ready_ignores_wake_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ready && !pd_partial_req && !pd_slumber_req) |=> phy_ready);

endmodule

bind link_pwr_ctrl lpc_checker #(.SPD_W(SPD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .init_done      (init_done),
  .init_speed     (init_speed),
  .pd_partial_req (pd_partial_req),
  .pd_slumber_req (pd_slumber_req),
  .wake_local     (wake_local),
  .wake_remote    (wake_remote),
  .link_up        (link_up),
  .phy_ready      (phy_ready),
  .pwr_state      (pwr_state),
  .comwake_tx     (comwake_tx),
  .align_tx       (align_tx),
  .link_speed     (link_speed),
  .exit_fault     (exit_fault)
);

// File: tb/link_pwr_ctrl_bench.sv
module link_pwr_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SPD_W = 2;
  localparam int PAR   = 12;
  localparam int SLU   = 40;

  // model state codes
  localparam int M_OFF = 0, M_RDY = 1, M_PAR = 2, M_SLU = 3, M_WL = 4, M_WR = 5, M_FLT = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             init_done, pd_partial_req, pd_slumber_req;
  logic             wake_local, wake_remote, link_up;
  logic [SPD_W-1:0] init_speed;
  logic             phy_ready, comwake_tx, align_tx, exit_fault;
  logic [1:0]       pwr_state;
  logic [SPD_W-1:0] link_speed;

  int n_chk  = 0;
  int n_fail = 0;

  int m_st, m_cnt, m_lim;
  int m_spd;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_pwr_ctrl #(
    .SPD_W (SPD_W), .PARTIAL_EXIT_CYC (PAR), .SLUMBER_EXIT_CYC (SLU)
  ) u_link_pwr_ctrl (
    .clk (clk), .rst_n (rst_n), .init_done (init_done), .init_speed (init_speed),
    .pd_partial_req (pd_partial_req), .pd_slumber_req (pd_slumber_req),
    .wake_local (wake_local), .wake_remote (wake_remote), .link_up (link_up),
    .phy_ready (phy_ready), .pwr_state (pwr_state), .comwake_tx (comwake_tx),
    .align_tx (align_tx), .link_speed (link_speed), .exit_fault (exit_fault)
  );

  function automatic int exp_pstate(int st);
    case (st)
      M_RDY:   return 0;
      M_PAR:   return 1;
      M_SLU:   return 2;
      default: return 3;
    endcase
  endfunction

  function automatic string tag_of(int st);
    case (st)
      M_OFF:   return "R1";
      M_RDY:   return "R2";
      M_PAR:   return "R3";
      M_SLU:   return "R3";
      M_WL:    return "R6";
      M_WR:    return "R5";
      default: return "R10";
    endcase
  endfunction

  // packs outputs as {phy_ready, pwr_state, comwake, align, fault, speed}
  function automatic int exp_vec(int st, int spd);
    int v;
    v = (st == M_RDY) ? 1 : 0;
    v = (v << 2) | exp_pstate(st);
    v = (v << 1) | ((st == M_WL) ? 1 : 0);
    v = (v << 1) | ((st == M_WL || st == M_WR) ? 1 : 0);
    v = (v << 1) | ((st == M_FLT) ? 1 : 0);
    v = (v << SPD_W) | spd;
    return v;
  endfunction

  function automatic int act_vec();
    int v;
    v = int'(phy_ready);
    v = (v << 2) | int'(pwr_state);
    v = (v << 1) | int'(comwake_tx);
    v = (v << 1) | int'(align_tx);
    v = (v << 1) | int'(exit_fault);
    v = (v << SPD_W) | int'(link_speed);
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // requirement-level model step, applied on the same edge as the DUT
  task automatic model_step();
    case (m_st)
      M_OFF: if (init_done) begin m_st = M_RDY; m_spd = int'(init_speed); end
      M_RDY: begin
        if (pd_slumber_req)      m_st = M_SLU;
        else if (pd_partial_req) m_st = M_PAR;
      end
      M_PAR, M_SLU: begin
        if (wake_remote || wake_local) begin
          m_lim = (m_st == M_SLU) ? SLU : PAR;
          m_cnt = 0;
          m_st  = wake_remote ? M_WR : M_WL;
        end
      end
      M_WL, M_WR: begin
        m_cnt++;
        if (link_up)             m_st = M_RDY;
        else if (m_cnt == m_lim) m_st = M_FLT;
      end
      default: begin m_st = M_OFF; m_spd = 0; end
    endcase
  endtask

  task automatic tick(input logic ini, input logic [SPD_W-1:0] spd, input logic pp,
                      input logic ps, input logic wl, input logic wr, input logic lu);
    @(negedge clk);
    init_done = ini; init_speed = spd; pd_partial_req = pp; pd_slumber_req = ps;
    wake_local = wl; wake_remote = wr; link_up = lu;
    @(posedge clk);
    model_step();
    #1;
    chk(tag_of(m_st), act_vec(), exp_vec(m_st, m_spd));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1A2B);
    rst_n = 1'b0;
    init_done = 0; init_speed = 0; pd_partial_req = 0; pd_slumber_req = 0;
    wake_local = 0; wake_remote = 0; link_up = 0;
    m_st = M_OFF; m_spd = 0; m_cnt = 0; m_lim = PAR;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", act_vec(), exp_vec(M_OFF, 0));
    @(negedge clk);
    rst_n = 1'b1;

    // R12: wake ignored while off
    tick(0, 0, 0, 0, 1, 1, 0);
    chk("R12", int'(pwr_state), 3);
    chk("R12", int'(align_tx), 0);
    // R2: capture speed
    tick(1, 2'd2, 0, 0, 0, 0, 0);
    chk("R2", int'(link_speed), 2);
    chk("R2", int'(phy_ready), 1);
    // R12: wake ignored while active
    tick(0, 0, 0, 0, 1, 1, 0);
    chk("R12", int'(phy_ready), 1);
    // R9: init ignored while active
    tick(1, 2'd1, 0, 0, 0, 0, 0);
    chk("R9", int'(link_speed), 2);
    // R3: both requests -> Slumber
    tick(0, 0, 1, 1, 0, 0, 0);
    chk("R3", int'(pwr_state), 2);
    // R4: requests ignored in Slumber
    tick(0, 0, 1, 0, 0, 0, 0);
    chk("R4", int'(pwr_state), 2);
    tick(0, 0, 0, 1, 0, 0, 0);
    chk("R4", int'(pwr_state), 2);
    // R6: local wake from Slumber, then R11 timeout at SLU edges
    tick(0, 0, 0, 0, 1, 0, 0);
    chk("R6", int'(comwake_tx), 1);
    idle(SLU - 1);
    chk("R11", int'(align_tx), 1);
    chk("R11", int'(exit_fault), 0);
    tick(0, 0, 0, 0, 0, 0, 0);
    chk("R11", int'(exit_fault), 1);
    tick(0, 0, 0, 0, 0, 0, 0);
    chk("R10", int'(link_speed), 0);
    chk("R10", int'(exit_fault), 0);
    // R7: simultaneous wake, R8 link_up on last allowed edge
    tick(1, 2'd3, 0, 0, 0, 0, 0);
    tick(0, 0, 1, 0, 0, 0, 0);
    chk("R3", int'(pwr_state), 1);
    tick(0, 0, 0, 0, 1, 1, 0);
    chk("R7", int'(comwake_tx), 0);
    chk("R7", int'(align_tx), 1);
    idle(PAR - 1);
    tick(0, 0, 0, 0, 0, 0, 1);
    chk("R8", int'(phy_ready), 1);
    chk("R9", int'(link_speed), 3);
    // R5 + R10: remote wake from Partial times out
    tick(0, 0, 1, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 1, 0);
    chk("R5", int'(align_tx), 1);
    chk("R5", int'(phy_ready), 0);
    idle(PAR - 1);
    chk("R10", int'(exit_fault), 0);
    tick(0, 0, 0, 0, 0, 0, 0);
    chk("R10", int'(exit_fault), 1);
    tick(0, 0, 0, 0, 0, 0, 0);
    chk("R10", int'(link_speed), 0);

    // constrained random phase, compared cycle by cycle with the model
    for (int i = 0; i < 6000; i++) begin
      logic ini, pp, ps, wl, wr, lu;
      logic [SPD_W-1:0] sp;
      ini = ($urandom % 4) == 0;
      sp  = SPD_W'($urandom);
      pp  = ($urandom % 6) == 0;
      ps  = ($urandom % 7) == 0;
      wl  = ($urandom % 5) == 0;
      wr  = ($urandom % 6) == 0;
      lu  = ($urandom % 24) == 0;
      tick(ini, sp, pp, ps, wl, wr, lu);
    end
    finish_run();
  end

endmodule